// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block generates a square wave of programmable period and duty from an 8-bit up counter. A prescaler turns the core clock into count ticks. On each tick the counter's value is compared with an active duty value and with a period value. On either match a single output flip-flop inverts. A match with the period value also sends the counter back to zero. Each match also gives a one-cycle interrupt pulse on its own output.

Software loads the period and duty values through two write strobes that share one data bus. With double buffering off, a duty write reaches the comparator at once. With double buffering on, the write goes into a holding register. The holding register is copied into the active duty value only when the period match occurs, so a duty change never cuts a cycle short. The counter runs only while the run input is high. Correct waveforms require a duty value below the period value.

The run control is a two-state machine. HALT holds the counter and prescaler at zero. RUN lets the counter advance on every tick. The START transition goes from HALT to RUN when run is high. The STOP transition goes from RUN to HALT when run is low.

Top module: `ppg_timer`

## Requirements
- R1: The counter starts at zero on the first tick after the run input rises and steps up by one per tick. On the tick where it equals the period value it returns to zero, so one period lasts period+1 ticks.
- R2: With the toggle enable high, the waveform output inverts on the clock edge of a tick whose count equals the duty value or the period value. It inverts only once if both match together.
- R3: With the toggle enable low, the waveform output holds its level whatever matches occur.
- R4: The prescale select sets the tick rate. Code 0 gives a tick every clock. Code 1 gives a tick every 4 clocks. Codes 2 and 3 give a tick every 16 clocks. While running, the first tick comes on the last clock of the first division.
- R5: While the run input is low, the counter and prescaler stay at zero, no interrupt is raised and the waveform output keeps its level.
- R6: The duty interrupt is high for exactly the one clock that follows a tick whose count equals the active duty value.
- R7: The period interrupt is high for exactly the one clock that follows a tick whose count equals the period value. In that clock the counter reads zero.
- R8: With double buffering off, a duty write changes the active duty value at the same clock edge. The write therefore governs every compare from the next edge onward.
- R9: With double buffering on, a duty write only loads the holding register. The holding register is copied into the active duty value at the period match. If a write lands on the same edge as that match, the newly written value is copied.
- R10: After reset the waveform output, both interrupts, the counter, the period value, the active duty value and the holding register are all zero.
- R11: A period write takes effect at its clock edge and governs every compare from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Prescale select (0: /1, 1: /4, 2 and 3: /16) |
| run_en | input | 1 | Counting enable |
| duty_wr | input | 1 | Write strobe for the duty value |
| period_wr | input | 1 | Write strobe for the period value |
| wr_data | input | 8 | Write data shared by both strobes |
| dbuf_en | input | 1 | Double buffering enable for the duty value |
| tog_en | input | 1 | Lets matches invert the output |
| wave_out | output | 1 | Waveform output |
| irq_duty | output | 1 | One-cycle pulse on a duty match |
| irq_period | output | 1 | One-cycle pulse on a period match |

## Verification
The risky overlap is a software duty write that arrives on the same clock edge as the period-match reload of the holding register. The bench sweeps the write position over every offset within a period with double buffering on, so one offset lands exactly on the wrap edge. It then compares the position of every following duty pulse and waveform edge against an arithmetic tick model that copies the freshly written value. The same sweep with double buffering off checks that an immediate write at the wrap edge is used from the next edge onward.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV16  = 2'd2,
        PS_DIV16B = 2'd3
    } ps_sel_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic duty;
        logic period;
    } match_t;

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler
    import ppg_pkg::*;
#(
    parameter int DIV_MID = 4,
    parameter int DIV_HI  = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_en,
    input  ps_sel_e sel,
    output logic    tick
);
    localparam int PW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    always_comb begin
        case (sel)
            PS_DIV1:  lim = '0;
            PS_DIV4:  lim = PW'(DIV_MID - 1);
            default:  lim = PW'(DIV_HI - 1);
        endcase
    end

    assign tick = run_en && (pre_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_en || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/ppg_duty_reg.sv
module ppg_duty_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] data,
    input  logic         dbuf_en,
    input  logic         reload,
    output logic [W-1:0] act_q,
    output logic [W-1:0] hold_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr) begin
            hold_q <= data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!dbuf_en) begin
            if (wr) begin
                act_q <= data;
            end
        end else if (reload) begin
            act_q <= wr ? data : hold_q;
        end
    end
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter
    import ppg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick,
    input  logic [W-1:0] duty_cmp,
    input  logic [W-1:0] period_cmp,
    output logic [W-1:0] cnt_q,
    output match_t       hit
);
    run_state_e state_q, state_d;
    logic       hold_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HALT: state_d = run_en ? ST_RUN : ST_HALT;   // START
            ST_RUN:  state_d = run_en ? ST_RUN : ST_HALT;   // STOP
        endcase
    end

    always_comb begin
        hold_zero  = (state_d == ST_HALT);
        hit.duty   = tick && (cnt_q == duty_cmp);
        hit.period = tick && (cnt_q == period_cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_zero) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= hit.period ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ppg_out.sv
module ppg_out
    import ppg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tog_en,
    input  match_t hit,
    output logic   wave_q,
    output logic   irq_d_q,
    output logic   irq_p_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q  <= 1'b0;
            irq_d_q <= 1'b0;
            irq_p_q <= 1'b0;
        end else begin
            irq_d_q <= hit.duty;
            irq_p_q <= hit.period;
            if (tog_en && (hit.duty || hit.period)) begin
                wave_q <= ~wave_q;
            end
        end
    end
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int W       = 8,
    parameter int DIV_MID = 4,
    parameter int DIV_HI  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   clk_sel,
    input  logic         run_en,
    input  logic         duty_wr,
    input  logic         period_wr,
    input  logic [W-1:0] wr_data,
    input  logic         dbuf_en,
    input  logic         tog_en,
    output logic         wave_out,
    output logic         irq_duty,
    output logic         irq_period
);
    logic         tick;
    logic [W-1:0] period_q;
    logic [W-1:0] duty_act;
    logic [W-1:0] duty_hold;
    logic [W-1:0] cnt_q;
    match_t       hit;
    logic         period_hit;
    logic         duty_hit;

    assign period_hit = hit.period;
    assign duty_hit   = hit.duty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (period_wr) begin
            period_q <= wr_data;
        end
    end

    ppg_prescaler #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .sel    (ps_sel_e'(clk_sel)),
        .tick   (tick)
    );

    ppg_duty_reg #(.W(W)) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (duty_wr),
        .data    (wr_data),
        .dbuf_en (dbuf_en),
        .reload  (period_hit),
        .act_q   (duty_act),
        .hold_q  (duty_hold)
    );

    ppg_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .tick       (tick),
        .duty_cmp   (duty_act),
        .period_cmp (period_q),
        .cnt_q      (cnt_q),
        .hit        (hit)
    );

    ppg_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_en  (tog_en),
        .hit     (hit),
        .wave_q  (wave_out),
        .irq_d_q (irq_duty),
        .irq_p_q (irq_period)
    );
endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         tog_en,
    input logic         dbuf_en,
    input logic         wave_out,
    input logic         irq_duty,
    input logic         irq_period,
    input logic [W-1:0] cnt,
    input logic [W-1:0] duty_act,
    input logic         duty_hit,
    input logic         reload
);
    // R5
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> cnt == '0);

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(wave_out));

    // R3
    tog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_en |=> $stable(wave_out));

    // R2
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_en && (duty_hit || reload)) |=> wave_out != $past(wave_out));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_period |-> cnt == '0);

    // R6
    irq_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_duty || irq_period) |-> $past(run_en));

    // R9
    dbuf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en && !reload) |=> $stable(duty_act));
endmodule

bind ppg_timer ppg_timer_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tog_en     (tog_en),
    .dbuf_en    (dbuf_en),
    .wave_out   (wave_out),
    .irq_duty   (irq_duty),
    .irq_period (irq_period),
    .cnt        (cnt_q),
    .duty_act   (duty_act),
    .duty_hit   (duty_hit),
    .reload     (period_hit)
);

// File: tb/sim_ppg_timer.sv
module sim_ppg_timer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] clk_sel;
    logic       run_en, duty_wr, period_wr, dbuf_en, tog_en;
    logic [7:0] wr_data;
    logic       wave_out, irq_duty, irq_period;

    always #2 clk = ~clk;   // 4 time units: 250 MHz

    ppg_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel),
        .run_en     (run_en),
        .duty_wr    (duty_wr),
        .period_wr  (period_wr),
        .wr_data    (wr_data),
        .dbuf_en    (dbuf_en),
        .tog_en     (tog_en),
        .wave_out   (wave_out),
        .irq_duty   (irq_duty),
        .irq_period (irq_period)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // arithmetic tick model built from the requirements
    int         m_pre  = 0;
    logic [7:0] m_cnt  = '0;
    logic [7:0] m_dact = '0;
    logic [7:0] m_hold = '0;
    logic [7:0] m_per  = '0;
    logic       m_wave = 1'b0;
    logic       m_id   = 1'b0;
    logic       m_ip   = 1'b0;

    function automatic int div_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;   // R4
    endfunction

    task automatic step(input logic wd, input logic wp, input logic [7:0] data, input string tag);
        logic tk, dm, pm;
        duty_wr   = wd;
        period_wr = wp;
        wr_data   = data;
        @(posedge clk);
        tk    = run_en && (m_pre >= div_of(clk_sel) - 1);
        m_pre = (!run_en || tk) ? 0 : m_pre + 1;
        dm    = tk && (m_cnt == m_dact);
        pm    = tk && (m_cnt == m_per);
        if (!run_en)  m_cnt = '0;
        else if (tk)  m_cnt = pm ? 8'd0 : 8'(m_cnt + 8'd1);
        if (tog_en && (dm || pm)) m_wave = ~m_wave;
        m_id = dm;
        m_ip = pm;
        if (wd) m_hold = data;
        if (!dbuf_en) begin
            if (wd) m_dact = data;
        end else if (pm) begin
            m_dact = m_hold;
        end
        if (wp) m_per = data;
        @(negedge clk);
        duty_wr   = 1'b0;
        period_wr = 1'b0;
        n_chk++;
        if ({wave_out, irq_duty, irq_period} !== {m_wave, m_id, m_ip}) begin
            n_fail++;
            $display("FAIL %s: wave,irq_duty,irq_period got %b%b%b expected %b%b%b",
                     tag, wave_out, irq_duty, irq_period, m_wave, m_id, m_ip);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL R10: watchdog got no completion expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; clk_sel = 2'd0; run_en = 1'b0; duty_wr = 1'b0;
        period_wr = 1'b0; dbuf_en = 1'b0; tog_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        n_chk++;
        if ({wave_out, irq_duty, irq_period} !== 3'b000) begin
            n_fail++;
            $display("FAIL R10: outputs got %b%b%b expected 000", wave_out, irq_duty, irq_period);
        end
        step(0, 0, 0, "R10");

        // R1 R2 R4 R6 R7 R5: sweep of prescale codes, periods and duties
        tog_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int pi = 0; pi < 3; pi++) begin
                int p;
                p = (pi == 0) ? 1 : (pi == 1) ? 3 : 6;
                for (int d = 0; d < p; d++) begin
                    clk_sel = 2'(s);
                    step(0, 1, 8'(p), "R11");
                    step(1, 0, 8'(d), "R8");
                    run_en = 1'b1;
                    repeat (2 * (p + 1) * div_of(2'(s)) + 3) step(0, 0, 0, "R1/R4/R6/R7");
                    run_en = 1'b0;
                    step(0, 0, 0, "R5");
                    step(0, 0, 0, "R5");
                end
            end
        end

        // R3: toggle enable low, then re-enabled while running
        clk_sel = 2'd0;
        step(0, 1, 8'd4, "R11");
        step(1, 0, 8'd1, "R8");
        tog_en = 1'b0;
        run_en = 1'b1;
        repeat (12) step(0, 0, 0, "R3");
        tog_en = 1'b1;
        repeat (12) step(0, 0, 0, "R2");
        run_en = 1'b0;
        step(0, 0, 0, "R5");

        // R9: buffered write swept over every offset, offset 7 hits the wrap edge
        for (int off = 0; off < 8; off++) begin
            dbuf_en = 1'b0;
            step(0, 1, 8'd7, "R11");
            step(1, 0, 8'd2, "R8");
            dbuf_en = 1'b1;
            run_en  = 1'b1;
            repeat (off) step(0, 0, 0, "R9");
            step(1, 0, 8'd5, "R9");
            repeat (20) step(0, 0, 0, "R9");
            run_en = 1'b0;
            step(0, 0, 0, "R5");
        end
        dbuf_en = 1'b0;

        // R8: immediate write swept over every offset
        for (int off = 0; off < 8; off++) begin
            step(1, 0, 8'd2, "R8");
            run_en = 1'b1;
            repeat (off) step(0, 0, 0, "R8");
            step(1, 0, 8'd5, "R8");
            repeat (20) step(0, 0, 0, "R8");
            run_en = 1'b0;
            step(0, 0, 0, "R5");
        end

        // R11: period shortened while running
        step(1, 0, 8'd1, "R8");
        step(0, 1, 8'd7, "R11");
        run_en = 1'b1;
        repeat (2) step(0, 0, 0, "R11");
        step(0, 1, 8'd3, "R11");
        repeat (20) step(0, 0, 0, "R11");
        run_en = 1'b0;
        step(0, 0, 0, "R5");

        done = 1'b1;
        finish_run();
    end
endmodule